// File: doc/BRIEF.md
# Edge-Driven Interrupt Redirection Controller

This block turns changes on a set of interrupt input lines into vector messages for processor targets. Each input line has a 64-bit redirection entry that tells the block whether the line may deliver, which 8-bit vector to send and which target should receive it. The destination value 0xFF is a broadcast to every target. The host reaches every internal register through two 32-bit bus locations. The first is a select register that holds an index. The second is a data window that reads or writes the register named by that index.

A message is produced only when a line goes from low to high. At that moment the line's entry must allow delivery: unmasked, edge mode, physical destination and fixed delivery. Any other setting produces nothing. Messages leave on a valid/ready port. When several lines rise while the port is stalled, one request per line waits, and the waiting requests are served lowest line number first.

The dispatch engine is a two-state machine. In ST_IDLE, the transition "grab" fires when any request is waiting. It claims the lowest waiting line, latches that line's vector and destination, and moves to ST_SEND. In ST_SEND the message is offered. The transition "accept" returns the machine to ST_IDLE when msg_ready is high. Otherwise the "stall" transition keeps it in ST_SEND.

Top module: `ric_top`

## Requirements
- R1: After reset no message is offered, and every entry reads 0x00010000 in its low half (index 0x10+2p) and 0x00010000 in its high half (index 0x11+2p), so bit 16 (mask) is set.
- R2: The bus accepts only accesses with bus_size equal to 4 at byte offset 0x00 or 0x10. Any other access reads 0 and changes no state when written.
- R3: A read at offset 0x00 returns the full 32-bit select register. Reads and writes at offset 0x10 act on the register whose index is the low 8 bits of the select register.
- R4: Line p has its low half at index 0x10+2p (bits 31:0) and its high half at index 0x11+2p (bits 63:32). A window write replaces only the half it addresses.
- R5: Index 0x00 keeps only bits 27:24 of a written value. Index 0x02 reads the same value as index 0x00. Index 0x01 reads 0x00NN0011, where NN is the line count (0x10). Writes to indices 0x01 and 0x02 have no effect. Indices that map to nothing read 0.
- R6: A message is produced only when a line goes from low to high. Holding a line high or lowering it produces nothing.
- R7: A rising line delivers only when all of these hold: bit 16 (mask) is 0, bit 15 (trigger, 1 = level) is 0, bit 11 (destination mode, 1 = logical) is 0, and bits 10:8 (delivery mode) are 000. Any other setting produces no message.
- R8: The message vector is entry bits 7:0 and msg_dest is entry bits 63:56. msg_bcast is 1 exactly when msg_dest is 0xFF.
- R9: Once msg_valid is high, it stays high with an unchanged payload until a clock edge at which msg_ready is high.
- R10: Rises on distinct lines that arrive while the output is stalled are all delivered, lowest line number first.
- R11: msg_valid goes high after the second clock edge that samples the newly raised line, provided the output is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read |
| irq_in | input | 16 | Interrupt input lines, active high |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_dest | output | 8 | Destination target ID |
| msg_bcast | output | 1 | Broadcast flag |
| msg_vector | output | 8 | Interrupt vector |

## Verification
A corrupted entry half or select register shows at the ports on the very next window read. It also shows as a wrong vector or destination in the next message from that line. A stuck or lost waiting request shows in one of two ways: a missing message, or messages that arrive out of line order once the stalled output is released. A misbehaving edge detector or eligibility check shows up two clock edges after a line rises, either as a spurious msg_valid or as a missing one.

// File: rtl/ric_pkg.sv
package ric_pkg;
    localparam int          ENT_W       = 64;
    localparam int          DATA_W      = 32;
    localparam logic [63:0] ENT_RESET   = 64'h0001_0000_0001_0000;
    localparam int          MASK_BIT    = 16;
    localparam int          TRIG_BIT    = 15;
    localparam int          DMODE_BIT   = 11;
    localparam int          DLV_LO      = 8;
    localparam int          DLV_HI      = 10;
    localparam int          DEST_LO     = 56;
    localparam logic [7:0]  IDX_ID      = 8'h00;
    localparam logic [7:0]  IDX_VER     = 8'h01;
    localparam logic [7:0]  IDX_ARB     = 8'h02;
    localparam logic [7:0]  VER_CODE    = 8'h11;
    localparam logic [7:0]  BCAST_DEST  = 8'hFF;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } ric_state_t;
endpackage

// File: rtl/ric_regfile.sv
module ric_regfile
    import ric_pkg::*;
#(
    parameter int         NUM_PINS = 16,
    parameter logic [7:0] IDX_BASE = 8'h10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              win_we,
    input  logic [7:0]                        win_idx,
    input  logic [DATA_W-1:0]                 win_wdata,
    output logic [DATA_W-1:0]                 win_rdata,
    output logic [NUM_PINS-1:0][ENT_W-1:0]    entries
);
    localparam logic [7:0] PIN_COUNT = 8'(NUM_PINS);

    logic [3:0] id_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0;
        end else if (win_we && win_idx == IDX_ID) begin
            id_q <= win_wdata[27:24];
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
        localparam logic [7:0] LO_IDX = 8'(int'(IDX_BASE) + 2 * p);
        localparam logic [7:0] HI_IDX = 8'(int'(IDX_BASE) + 2 * p + 1);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[p] <= ENT_RESET;
            end else if (win_we && win_idx == LO_IDX) begin
                entries[p][31:0] <= win_wdata;
            end else if (win_we && win_idx == HI_IDX) begin
                entries[p][63:32] <= win_wdata;
            end
        end
    end

    always_comb begin
        win_rdata = '0;
        unique case (win_idx)
            IDX_ID:  win_rdata = {4'h0, id_q, 24'h0};
            IDX_VER: win_rdata = {8'h00, PIN_COUNT, 8'h00, VER_CODE};
            IDX_ARB: win_rdata = {4'h0, id_q, 24'h0};
            default: begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (win_idx == 8'(int'(IDX_BASE) + 2 * p))
                        win_rdata = entries[p][31:0];
                    if (win_idx == 8'(int'(IDX_BASE) + 2 * p + 1))
                        win_rdata = entries[p][63:32];
                end
            end
        endcase
    end
endmodule

// File: rtl/ric_edge_q.sv
module ric_edge_q
    import ric_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PINS-1:0]            irq_in,
    input  logic [NUM_PINS-1:0][ENT_W-1:0] entries,
    input  logic [NUM_PINS-1:0]            clr,
    output logic [NUM_PINS-1:0]            pend
);
    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] elig;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_elig
        assign elig[p] = !entries[p][MASK_BIT]
                       && !entries[p][TRIG_BIT]
                       && !entries[p][DMODE_BIT]
                       && (entries[p][DLV_HI:DLV_LO] == 3'b000);
    end

    assign rise = irq_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend   <= '0;
        end else begin
            prev_q <= irq_in;
            pend   <= (pend & ~clr) | (rise & elig);
        end
    end
endmodule

// File: rtl/ric_dispatch.sv
module ric_dispatch
    import ric_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PINS-1:0]            pend,
    input  logic [NUM_PINS-1:0][ENT_W-1:0] entries,
    input  logic                           msg_ready,
    output logic [NUM_PINS-1:0]            clr,
    output logic                           msg_valid,
    output logic [7:0]                     msg_dest,
    output logic                           msg_bcast,
    output logic [7:0]                     msg_vector
);
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    ric_state_t      state_q, state_n;
    logic            any;
    logic [PIN_W-1:0] pick;

    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any  = 1'b1;
                pick = PIN_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        clr     = '0;
        unique case (state_q)
            ST_IDLE: if (any) begin
                state_n    = ST_SEND;
                clr[pick]  = 1'b1;
            end
            ST_SEND: if (msg_ready) state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_dest   <= '0;
            msg_bcast  <= 1'b0;
            msg_vector <= '0;
        end else if (state_q == ST_IDLE && any) begin
            msg_dest   <= entries[pick][DEST_LO +: 8];
            msg_bcast  <= (entries[pick][DEST_LO +: 8] == BCAST_DEST);
            msg_vector <= entries[pick][7:0];
        end
    end

    assign msg_valid = (state_q == ST_SEND);
endmodule

// File: rtl/ric_top.sv
module ric_top
    import ric_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2:0]          bus_size,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] irq_in,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_dest,
    output logic                msg_bcast,
    output logic [7:0]          msg_vector
);
    localparam logic [ADDR_W-1:0] OFF_SEL = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFF_WIN = ADDR_W'(8'h10);

    logic [DATA_W-1:0]              sel_q;
    logic [DATA_W-1:0]              win_rdata;
    logic [NUM_PINS-1:0][ENT_W-1:0] entries;
    logic [NUM_PINS-1:0]            pend_w;
    logic [NUM_PINS-1:0]            clr_w;
    logic acc_ok, at_sel, at_win, win_we;

    assign at_sel = (bus_addr == OFF_SEL);
    assign at_win = (bus_addr == OFF_WIN);
    assign acc_ok = bus_en && (bus_size == 3'd4) && (at_sel || at_win);
    assign win_we = acc_ok && bus_we && at_win;

    always_ff @(posedge clk) begin
        if (!rst_n)                       sel_q <= '0;
        else if (acc_ok && bus_we && at_sel) sel_q <= bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        if (acc_ok && !bus_we) bus_rdata = at_sel ? sel_q : win_rdata;
    end

    ric_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_idx(sel_q[7:0]),
        .win_wdata(bus_wdata), .win_rdata(win_rdata), .entries(entries)
    );

    ric_edge_q #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .entries(entries),
        .clr(clr_w), .pend(pend_w)
    );

    ric_dispatch #(.NUM_PINS(NUM_PINS)) u_disp (
        .clk(clk), .rst_n(rst_n), .pend(pend_w), .entries(entries),
        .msg_ready(msg_ready), .clr(clr_w), .msg_valid(msg_valid),
        .msg_dest(msg_dest), .msg_bcast(msg_bcast), .msg_vector(msg_vector)
    );
endmodule

// File: rtl/ric_check.sv
module ric_check #(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_en,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [2:0]          bus_size,
    input logic [31:0]         bus_rdata,
    input logic [31:0]         sel_q,
    input logic [NUM_PINS-1:0] pend_w,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [7:0]          msg_dest,
    input logic                msg_bcast,
    input logic [7:0]          msg_vector
);
    a_r9_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector)
                                    && $stable(msg_dest) && $stable(msg_bcast));

    a_r2_bad_write_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && bus_we && !(bus_size == 3'd4 && (bus_addr == ADDR_W'(8'h00)
                                                   || bus_addr == ADDR_W'(8'h10)))
        |=> $stable(sel_q));

    a_r2_bad_size_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && !bus_we && bus_size != 3'd4 |-> bus_rdata == 32'h0);

    a_r10_msg_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(|pend_w));

    a_r8_bcast_flag: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_bcast == (msg_dest == 8'hFF)));
endmodule

bind ric_top ric_check #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_rdata(bus_rdata),
    .sel_q(sel_q), .pend_w(pend_w), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_bcast(msg_bcast),
    .msg_vector(msg_vector)
);

// File: tb/ric_top_test.sv
module ric_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [15:0] irq_in = '0;
    logic        msg_valid, msg_ready = 1'b0, msg_bcast;
    logic [7:0]  msg_dest, msg_vector;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [16:0] exp_q[$];

    always #10 clk = ~clk;

    ric_top uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus(input logic we, input logic [7:0] a, input logic [2:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_en = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
        #5 rd = bus_rdata;
        @(posedge clk);
        #1 bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
        logic [31:0] x;
        bus(1'b1, 8'h00, 3'd4, {24'h0, idx}, x);
        bus(1'b1, 8'h10, 3'd4, d, x);
    endtask

    task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
        logic [31:0] x;
        bus(1'b1, 8'h00, 3'd4, {24'h0, idx}, x);
        bus(1'b0, 8'h10, 3'd4, 32'h0, d);
    endtask

    function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic m,
                                            input logic t, input logic dm, input logic [2:0] dl);
        return {15'h0, m, t, 3'b000, dm, dl, vec};
    endfunction

    task automatic set_pin(input int p, input logic [7:0] vec, input logic [7:0] dest);
        win_wr(8'(16 + 2 * p), lo_word(vec, 1'b0, 1'b0, 1'b0, 3'b000));
        win_wr(8'(17 + 2 * p), {dest, 24'h0});
    endtask

    task automatic expect_msg(input logic [7:0] dest, input logic [7:0] vec);
        exp_q.push_back({dest, dest == 8'hFF, vec});
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: scoreboard pop on every handshake (R8, R9, R10)
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (rst_n && msg_valid && msg_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected message", {15'h0, msg_dest, msg_bcast, msg_vector}, 32'h0);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    chk("R8/R10 message", {15'h0, msg_dest, msg_bcast, msg_vector}, {15'h0, e});
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        chk("R1 valid after reset", {31'h0, msg_valid}, 32'h0);
        win_rd(8'h10, r); chk("R1 pin0 low", r, 32'h0001_0000);
        win_rd(8'h11, r); chk("R1 pin0 high", r, 32'h0001_0000);
        win_rd(8'h2F, r); chk("R1 pin15 high", r, 32'h0001_0000);

        // R5 fixed registers
        win_wr(8'h00, 32'hFFFF_FFFF);
        win_rd(8'h00, r); chk("R5 id mask", r, 32'h0F00_0000);
        win_rd(8'h02, r); chk("R5 arb mirrors id", r, 32'h0F00_0000);
        win_rd(8'h01, r); chk("R5 version", r, 32'h0010_0011);
        win_wr(8'h01, 32'h1234_5678); win_wr(8'h02, 32'h0);
        win_rd(8'h01, r); chk("R5 version write ignored", r, 32'h0010_0011);
        win_rd(8'h02, r); chk("R5 arb write ignored", r, 32'h0F00_0000);
        win_rd(8'h30, r); chk("R5 unmapped above table", r, 32'h0);
        win_rd(8'h07, r); chk("R5 unmapped gap", r, 32'h0);

        // R3 select readback and low-byte indexing
        bus(1'b1, 8'h00, 3'd4, 32'hABCD_0014, r);
        bus(1'b0, 8'h00, 3'd4, 32'h0, r); chk("R3 select readback", r, 32'hABCD_0014);
        bus(1'b1, 8'h10, 3'd4, 32'h0000_5A5A, r);
        win_rd(8'h14, r); chk("R3 window via low byte", r, 32'h0000_5A5A);

        // R4 half replacement
        win_wr(8'h16, 32'h1111_1111); win_wr(8'h17, 32'h2222_2222);
        win_wr(8'h16, 32'h3333_3333);
        win_rd(8'h17, r); chk("R4 high half kept", r, 32'h2222_2222);
        win_rd(8'h16, r); chk("R4 low half replaced", r, 32'h3333_3333);

        // R2 access checking
        bus(1'b1, 8'h00, 3'd4, 32'h0000_0016, r);
        bus(1'b0, 8'h10, 3'd2, 32'h0, r); chk("R2 size 2 read zero", r, 32'h0);
        bus(1'b0, 8'h04, 3'd4, 32'h0, r); chk("R2 offset 4 read zero", r, 32'h0);
        bus(1'b1, 8'h08, 3'd4, 32'h0000_0030, r);
        bus(1'b1, 8'h00, 3'd2, 32'h0000_0031, r);
        bus(1'b0, 8'h00, 3'd4, 32'h0, r); chk("R2 bad writes keep select", r, 32'h0000_0016);
        bus(1'b1, 8'h10, 3'd1, 32'hDEAD_BEEF, r);
        bus(1'b0, 8'h10, 3'd4, 32'h0, r); chk("R2 bad write keeps entry", r, 32'h3333_3333);

        // R11 latency, R9 hold, R8 unicast
        set_pin(2, 8'h42, 8'h05);
        @(negedge clk); irq_in[2] = 1'b1;
        @(negedge clk); chk("R11 not valid after one edge", {31'h0, msg_valid}, 32'h0);
        @(negedge clk); chk("R11 valid after two edges", {31'h0, msg_valid}, 32'h1);
        wait_cyc(3);
        chk("R9 valid held while stalled", {31'h0, msg_valid}, 32'h1);
        chk("R8 unicast payload", {15'h0, msg_dest, msg_bcast, msg_vector}, {15'h0, 8'h05, 1'b0, 8'h42});
        expect_msg(8'h05, 8'h42);
        msg_ready = 1'b1;
        wait_cyc(3);
        chk("R9 accepted", {31'h0, msg_valid}, 32'h0);

        // R6 held high and falling produce nothing
        wait_cyc(4);
        irq_in[2] = 1'b0;
        wait_cyc(5);
        chk("R6 no message on hold or fall", {31'h0, msg_valid}, 32'h0);
        chk("R6 scoreboard drained", exp_q.size(), 32'h0);

        // R7 ineligible entries
        set_pin(5, 8'h55, 8'h01);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] w;
            case (k)
                0: w = lo_word(8'h55, 1'b1, 1'b0, 1'b0, 3'b000);
                1: w = lo_word(8'h55, 1'b0, 1'b1, 1'b0, 3'b000);
                2: w = lo_word(8'h55, 1'b0, 1'b0, 1'b1, 3'b000);
                default: w = lo_word(8'h55, 1'b0, 1'b0, 1'b0, 3'b001);
            endcase
            win_wr(8'h1A, w);
            @(negedge clk); irq_in[5] = 1'b1;
            wait_cyc(4);
            chk("R7 ineligible entry silent", {31'h0, msg_valid}, 32'h0);
            irq_in[5] = 1'b0;
            wait_cyc(2);
        end

        // R8 broadcast
        set_pin(9, 8'h99, 8'hFF);
        expect_msg(8'hFF, 8'h99);
        @(negedge clk); irq_in[9] = 1'b1;
        wait_cyc(4);
        irq_in[9] = 1'b0;
        chk("R8 broadcast delivered", exp_q.size(), 32'h0);

        // R10 queued rises, lowest first
        msg_ready = 1'b0;
        set_pin(7, 8'h77, 8'h07);
        set_pin(1, 8'h11, 8'h03);
        set_pin(4, 8'h44, 8'hFF);
        @(negedge clk); irq_in[7] = 1'b1; irq_in[1] = 1'b1; irq_in[4] = 1'b1;
        wait_cyc(4);
        chk("R10 first offered is lowest", {24'h0, msg_vector}, 32'h11);
        expect_msg(8'h03, 8'h11);
        expect_msg(8'hFF, 8'h44);
        expect_msg(8'h07, 8'h77);
        msg_ready = 1'b1;
        wait_cyc(10);
        chk("R10 all queued delivered", exp_q.size(), 32'h0);
        irq_in = '0;
        wait_cyc(3);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule